// File: doc/BRIEF.md
# First-Order Wave Digital Allpass Section

This block is a recursive first-order allpass stage built from a symmetric two-port wave adaptor. The incoming sample enters adaptor port 1. Port 2 is closed through a single delay register. The wave reflected at port 1 is the section output, and the wave leaving port 2 is written back into the delay register. The transfer function is (t0 + z^-1) / (1 + t0·z^-1) with t0 = -gamma.

The lattice coefficient gamma may be anywhere in (-1, 1). It is never multiplied directly. A build-time parameter selects one of four adaptor arrangements, and each arrangement uses a positive multiplier alpha between 0 and 1/2. Alpha is given as two 9-bit digit masks in canonical signed-digit form, so the multiplier becomes a few shifted adds.

Samples move over a valid/ready stream on both sides, with one output register. A new sample can be taken only when the output register is empty or is being drained in the same cycle. A stalled consumer therefore holds the producer back, and the recursion state advances once for each accepted sample. Two instances placed in series give a second-order section.

Top module: `wdf_allpass1`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the delay state is zero.
- R2: in_ready is 1 exactly when out_valid is 0 or out_ready is 1.
- R3: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change.
- R4: A sample is accepted on a clock edge where in_valid and in_ready are both 1. After that edge, out_valid is 1 and out_data holds that sample's result. If out_ready is 1 on an edge where no sample is accepted, out_valid falls to 0.
- R5: alpha = (P - N) / 512, where P and N are the 9-bit positive-digit and negative-digit masks and bit j carries weight 2^j. The product p = alpha·(a2 - a1) is rounded toward minus infinity.
- R6: Type 1 (gamma = 1 - alpha) computes b1 = 2·a2 - a1 - p and b2 = a2 - p.
- R7: Type 2 (gamma = alpha) computes b1 = a2 + p and b2 = a1 + p.
- R8: Type 3 (gamma = -alpha) computes b1 = a2 - p and b2 = a1 - p.
- R9: Type 4 (gamma = alpha - 1) computes b1 = a1 + p and b2 = 2·a1 - a2 + p.
- R10: a1 is the input sample and a2 is the delay state. out_data is b1 saturated to the signed range of DW bits. The next state is b2 saturated to the signed range of DW+GUARD bits (14 bits by default).
- R11: The delay state and the pending output change only on acceptance or drain. Cycles with no accepted sample leave the next result unaffected.
- R12: For Type 2 with alpha = 1/4 starting from reset, the input 64, 0, 0 gives the outputs -16, 60, 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Section can take a sample this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | DW | Signed section output |

## Verification
A corrupted delay state does not show at once. The next accepted sample still gives the right result if a1 dominates. After that, every output differs from an independently computed recursion, and the error decays only at the rate |gamma| per sample. For that reason, each of the four adaptor types is run against its own model over long random streams, with gamma close to ±1 included. A handshake fault shows up within a cycle, as a lost, duplicated or altered result while the consumer stalls.

// File: rtl/wdf_ap_pkg.sv
package wdf_ap_pkg;
  localparam int ADP_T1 = 1;  // gamma above one half
  localparam int ADP_T2 = 2;  // gamma in (0, 1/2]
  localparam int ADP_T3 = 3;  // gamma in [-1/2, 0)
  localparam int ADP_T4 = 4;  // gamma below minus one half

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/wdf_csd_scaler.sv
module wdf_csd_scaler #(
  parameter int W = 17,
  parameter int FRAC = 9,
  parameter logic [FRAC-1:0] POS = '0,
  parameter logic [FRAC-1:0] NEG = '0
) (
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  localparam int PW = W + FRAC + 1;

  logic signed [PW-1:0] ext;
  logic signed [PW-1:0] term [FRAC];
  logic signed [PW-1:0] acc;

  assign ext = {{(PW-W){din[W-1]}}, din};

  for (genvar j = 0; j < FRAC; j++) begin : g_digit
    if (POS[j]) begin : g_plus
      assign term[j] = ext <<< j;
    end else if (NEG[j]) begin : g_minus
      assign term[j] = -(ext <<< j);
    end else begin : g_zero
      assign term[j] = '0;
    end
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < FRAC; j++) acc = acc + term[j];
  end

  // one final arithmetic shift: floor of the exact product
  assign dout = W'(acc >>> FRAC);
endmodule

// File: rtl/wdf_adaptor_core.sv
module wdf_adaptor_core #(
  parameter int W = 17,
  parameter int TYPE = 1,
  parameter int FRAC = 9,
  parameter logic [FRAC-1:0] POS = '0,
  parameter logic [FRAC-1:0] NEG = '0
) (
  input  logic signed [W-1:0] a1,
  input  logic signed [W-1:0] a2,
  output logic signed [W-1:0] b1,
  output logic signed [W-1:0] b2
);
  import wdf_ap_pkg::*;

  logic signed [W-1:0] diff;
  logic signed [W-1:0] prod;

  assign diff = a2 - a1;

  wdf_csd_scaler #(.W(W), .FRAC(FRAC), .POS(POS), .NEG(NEG)) u_mul (
    .din (diff),
    .dout(prod)
  );

  if (TYPE == ADP_T1) begin : g_t1
    assign b1 = a2 + diff - prod;
    assign b2 = a2 - prod;
  end else if (TYPE == ADP_T2) begin : g_t2
    assign b1 = a2 + prod;
    assign b2 = a1 + prod;
  end else if (TYPE == ADP_T3) begin : g_t3
    assign b1 = a2 - prod;
    assign b2 = a1 - prod;
  end else begin : g_t4
    assign b1 = a1 + prod;
    assign b2 = a1 - diff + prod;
  end
endmodule

// File: rtl/wdf_allpass1.sv
module wdf_allpass1 #(
  parameter int DW = 8,
  parameter int GUARD = 6,
  parameter int FRAC = 9,
  parameter int TYPE = 1,
  parameter logic [FRAC-1:0] ALPHA_POS = 9'h100,
  parameter logic [FRAC-1:0] ALPHA_NEG = 9'h045
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  import wdf_ap_pkg::*;

  localparam int IW = DW + GUARD;
  localparam int WW = IW + 3;
  localparam int YMAX = 2**(DW-1) - 1;
  localparam int YMIN = -(2**(DW-1));
  localparam int SMAX = 2**(IW-1) - 1;
  localparam int SMIN = -(2**(IW-1));

  logic signed [IW-1:0] state_q;
  logic signed [WW-1:0] a1_w, a2_w, b1_w, b2_w;
  logic        [DW-1:0] y_sat;
  logic signed [IW-1:0] s_sat;
  logic                 accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  assign a1_w = {{(WW-DW){in_data[DW-1]}}, in_data};
  assign a2_w = {{(WW-IW){state_q[IW-1]}}, state_q};

  wdf_adaptor_core #(.W(WW), .TYPE(TYPE), .FRAC(FRAC), .POS(ALPHA_POS), .NEG(ALPHA_NEG)) u_core (
    .a1(a1_w),
    .a2(a2_w),
    .b1(b1_w),
    .b2(b2_w)
  );

  assign y_sat = DW'(clamp_int(int'(b1_w), YMIN, YMAX));
  assign s_sat = IW'(clamp_int(int'(b2_w), SMIN, SMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (accept) begin
      state_q   <= s_sat;
      out_data  <= y_sat;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wdf_allpass1_chk.sv
module wdf_allpass1_chk #(
  parameter int DW = 8,
  parameter int IW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [IW-1:0] state_q
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(state_q));
endmodule

bind wdf_allpass1 wdf_allpass1_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .state_q(state_q)
);

// File: tb/wdf_allpass1_test.sv
module wdf_allpass1_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic       ir [4];
  logic       ov [4];
  logic [7:0] yo [4];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  int   typ [4] = '{1, 2, 3, 4};
  int   alp [4] = '{187, 128, 160, 53};
  string rq [4] = '{"R6", "R7", "R8", "R9"};
  int   st [4];
  int   ey [4];
  bit   ev;

  always #5 clk = ~clk;

  wdf_allpass1 #(.TYPE(1), .ALPHA_POS(9'h100), .ALPHA_NEG(9'h045)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[0]), .in_data(in_data),
    .out_valid(ov[0]), .out_ready(out_ready), .out_data(yo[0]));
  wdf_allpass1 #(.TYPE(2), .ALPHA_POS(9'h080), .ALPHA_NEG(9'h000)) uut_t2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[1]), .in_data(in_data),
    .out_valid(ov[1]), .out_ready(out_ready), .out_data(yo[1]));
  wdf_allpass1 #(.TYPE(3), .ALPHA_POS(9'h0A0), .ALPHA_NEG(9'h000)) uut_t3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[2]), .in_data(in_data),
    .out_valid(ov[2]), .out_ready(out_ready), .out_data(yo[2]));
  wdf_allpass1 #(.TYPE(4), .ALPHA_POS(9'h045), .ALPHA_NEG(9'h010)) uut_t4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir[3]), .in_data(in_data),
    .out_valid(ov[3]), .out_ready(out_ready), .out_data(yo[3]));

  function automatic int clampb(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // R5 R10 model: floor product, saturate output and state
  function automatic void model(int k, int x);
    int a1, a2, d, p, b1, b2;
    a1 = x; a2 = st[k]; d = a2 - a1;
    p = (d * alp[k]) >>> 9;
    case (typ[k])
      1: begin b1 = 2*a2 - a1 - p; b2 = a2 - p; end
      2: begin b1 = a2 + p;        b2 = a1 + p; end
      3: begin b1 = a2 - p;        b2 = a1 - p; end
      default: begin b1 = a1 + p;  b2 = 2*a1 - a2 + p; end
    endcase
    ey[k] = clampb(b1, -128, 127);
    st[k] = clampb(b2, -8192, 8191);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, evaluate after the edge at the next negedge
  task automatic step(bit v, int x, bit r);
    bit fire, cons;
    in_valid = v; in_data = 8'(x); out_ready = r;
    #1;
    check(ir[0] == (!ev || r), "R2", int'(ir[0]), int'(!ev || r));
    fire = v && ir[0];
    cons = ev && r;
    @(posedge clk);
    if (fire) begin
      for (int k = 0; k < 4; k++) model(k, x);
      ev = 1;
    end else if (cons) ev = 0;
    @(negedge clk);
    check(ov[0] == ev, "R4", int'(ov[0]), int'(ev));
    if (ev) begin
      for (int k = 0; k < 4; k++)
        check($signed(yo[k]) == ey[k], rq[k], int'($signed(yo[k])), ey[k]);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000 && !done) begin
        done = 1;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) begin st[k] = 0; ey[k] = 0; end
    ev = 0;
    repeat (3) @(negedge clk);
    check(ov[0] == 1'b0, "R1", int'(ov[0]), 0);
    check(ir[0] == 1'b1, "R1", int'(ir[0]), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 impulse through the type 2 instance with alpha 1/4
    step(1, 64, 1); check($signed(yo[1]) == -16, "R12", int'($signed(yo[1])), -16);
    step(1, 0, 1);  check($signed(yo[1]) == 60,  "R12", int'($signed(yo[1])), 60);
    step(1, 0, 1);  check($signed(yo[1]) == 15,  "R12", int'($signed(yo[1])), 15);

    // R4 drain with no new input
    step(0, 0, 1);
    check(ov[0] == 1'b0, "R4", int'(ov[0]), 0);

    // R3 stall: output held while the consumer is not ready
    step(1, 100, 0);
    held = yo[0];
    step(1, -50, 0);
    check(yo[0] == held, "R3", int'(yo[0]), int'(held));
    step(1, -50, 0);
    check(yo[0] == held, "R3", int'(yo[0]), int'(held));
    step(0, 0, 1);

    // R11 idle gap: state unchanged, next result from the old state
    repeat (5) step(0, 0, 0);
    step(1, 17, 1);

    // R10 extremes: full-scale square wave stresses saturation
    for (int i = 0; i < 40; i++) step(1, (i % 2) ? -128 : 127, 1);
    for (int i = 0; i < 20; i++) step(1, 127, 1);

    // constrained random traffic with random back-pressure
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, int'($urandom % 256) - 128, ($urandom % 3) != 0);

    // R1 reset clears state and output
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) st[k] = 0;
    ev = 0;
    check(ov[0] == 1'b0, "R1", int'(ov[0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 0, 1);
    check($signed(yo[2]) == 0, "R1", int'($signed(yo[2])), 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule